// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a shared memory with two independent synchronous ports, left and right, through which two processors exchange data. The two highest words of the array also act as mailboxes. When the left port writes the top word, the right processor's interrupt line goes low. When the right port writes the word just below the top, the left processor's interrupt line goes low. Each receiver drops its own interrupt by reading the mailbox that was posted to it. The mailbox words keep the written value like any other location, so the receiver reads the message in the same access that acknowledges it.

Each side has its own two-state flag machine. FLG_IDLE means no message is waiting and the interrupt output is high. FLG_PENDING means a message is waiting and the interrupt output is low. The transition *post* (FLG_IDLE to FLG_PENDING) is taken on the sender's write to the receiver's mailbox. The transition *take* (FLG_PENDING to FLG_IDLE) is taken on the receiver's read of that mailbox, unless a post happens in the same cycle. In every other case the state holds. The array depth is a parameter, and the mailbox addresses follow from it.

Top module: `mbx_dualport`

## Requirements
- R1: After reset both `l_irq_n` and `r_irq_n` are 1.
- R2: A write on either port stores `*_wdata` at `*_addr`. A read (`*_en`=1, `*_we`=0) presents the stored word on that port's `*_rdata` at the next clock edge. Either port can read what the other wrote.
- R3: A left-port write to address DEPTH-1 drives `r_irq_n` to 0 from the following clock edge.
- R4: A right-port write to address DEPTH-2 drives `l_irq_n` to 0 from the following clock edge.
- R5: A right-port read of DEPTH-1 returns `r_irq_n` to 1 from the following edge. A left-port read of DEPTH-2 returns `l_irq_n` to 1 from the following edge.
- R6: No other access changes an interrupt. This includes a sender reading its own outgoing mailbox, a receiver writing its incoming mailbox, and any access to another address.
- R7: If a post and a take of the same mailbox fall in the same cycle, the interrupt ends up asserted (0).
- R8: A mailbox word returns the message last written to it when read by either port.
- R9: When both ports write the same address in one cycle, the left port's data is stored.
- R10: A read in the same cycle as the other port's write to the same address returns the word held before that write.
- R11: A port's `*_rdata` holds its value in every cycle in which that port does not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write (1) or read (0) |
| l_addr | input | AW | Left port word address |
| l_wdata | input | DW | Left port write data |
| l_rdata | output | DW | Left port read data, one cycle after the read |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write (1) or read (0) |
| r_addr | input | AW | Right port word address |
| r_wdata | input | DW | Right port write data |
| r_rdata | output | DW | Right port read data, one cycle after the read |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every address below the mailboxes is written by one port with an arithmetic pattern and read back by the other, in both directions. This tells crossed data paths and address faults apart from correct storage, and an idle cycle after each read confirms that read data holds. The mailbox words are then driven through each combination of sender and receiver with reads and writes: sender reads, receiver writes and unrelated writes show that only a post or a take moves a flag. Same-cycle collisions are applied last: post with take, write with write to one address, and read with write to one address. These separate the chosen priorities from their opposites.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Per-side mailbox flag states
    typedef enum logic {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_t;

    localparam int NUM_PORTS = 2;
    localparam int PORT_L    = 0;
    localparam int PORT_R    = 1;

endpackage

// File: rtl/mbx_array.sv
module mbx_array #(
    parameter int DEPTH = 256,
    parameter int DW    = 16,
    parameter int NP    = 2,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NP-1:0]          en,
    input  logic [NP-1:0]          we,
    input  logic [NP-1:0][AW-1:0]  addr,
    input  logic [NP-1:0][DW-1:0]  wdata,
    output logic [NP-1:0][DW-1:0]  rdata
);

    logic [DW-1:0] store [DEPTH];

    // Writes: iterate from the highest port down so port 0 is applied last
    // and wins a same-address collision.
    always_ff @(posedge clk) begin
        for (int p = NP - 1; p >= 0; p--) begin
            if (en[p] && we[p]) begin
                store[addr[p]] <= wdata[p];
            end
        end
    end

    // Reads: registered, return the contents before this edge's writes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            for (int p = 0; p < NP; p++) begin
                if (en[p] && !we[p]) begin
                    rdata[p] <= store[addr[p]];
                end
            end
        end
    end

    for (genvar g = 0; g < NP; g++) begin : g_hold_chk
        // R11: read data is held while the port does not read
        assert_rdata_hold_R11: assert property (
            @(posedge clk) disable iff (!rst_n)
            !(en[g] && !we[g]) |=> $stable(rdata[g])
        );
    end

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic take,
    output logic irq_n
);

    flag_state_t state, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FLG_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Transitions: post wins over take in the same cycle
    always_comb begin
        nxt = state;
        unique case (state)
            FLG_IDLE: begin
                if (post) nxt = FLG_PENDING;
            end
            FLG_PENDING: begin
                if (take && !post) nxt = FLG_IDLE;
            end
            default: nxt = FLG_IDLE;
        endcase
    end

    // Output
    always_comb begin
        irq_n = (state != FLG_PENDING);
    end

    // R3 / R4 / R7: a post always leaves the interrupt asserted
    assert_post_sets_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        post |=> !irq_n
    );

    // R5: a take without a post releases the interrupt
    assert_take_clears_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (take && !post) |=> irq_n
    );

    // R6: nothing else moves the interrupt
    assert_idle_holds_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!take && !post) |=> $stable(irq_n)
    );

endmodule

// File: rtl/mbx_dualport.sv
module mbx_dualport
    import mbx_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int DW    = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_en,
    input  logic          l_we,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_irq_n,
    input  logic          r_en,
    input  logic          r_we,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_irq_n
);

    // Mailbox addresses: top word feeds the right side, the one below the left
    localparam logic [AW-1:0] BOX_TO_R = AW'(DEPTH - 1);
    localparam logic [AW-1:0] BOX_TO_L = AW'(DEPTH - 2);

    logic [NUM_PORTS-1:0]         en_v, we_v;
    logic [NUM_PORTS-1:0][AW-1:0] addr_v;
    logic [NUM_PORTS-1:0][DW-1:0] wdata_v, rdata_v;
    logic [NUM_PORTS-1:0]         post_v, take_v, irq_v;
    logic [NUM_PORTS-1:0][AW-1:0] inbox;

    always_comb begin
        en_v[PORT_L]    = l_en;
        we_v[PORT_L]    = l_we;
        addr_v[PORT_L]  = l_addr;
        wdata_v[PORT_L] = l_wdata;
        en_v[PORT_R]    = r_en;
        we_v[PORT_R]    = r_we;
        addr_v[PORT_R]  = r_addr;
        wdata_v[PORT_R] = r_wdata;
        inbox[PORT_L]   = BOX_TO_L;
        inbox[PORT_R]   = BOX_TO_R;
    end

    mbx_array #(.DEPTH(DEPTH), .DW(DW), .NP(NUM_PORTS)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_v),
        .we    (we_v),
        .addr  (addr_v),
        .wdata (wdata_v),
        .rdata (rdata_v)
    );

    // One flag per receiving side; the sender is always the other port
    for (genvar s = 0; s < NUM_PORTS; s++) begin : g_side
        localparam int OTHER = NUM_PORTS - 1 - s;

        always_comb begin
            post_v[s] = en_v[OTHER] && we_v[OTHER] && (addr_v[OTHER] == inbox[s]);
            take_v[s] = en_v[s] && !we_v[s] && (addr_v[s] == inbox[s]);
        end

        mbx_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .post  (post_v[s]),
            .take  (take_v[s]),
            .irq_n (irq_v[s])
        );
    end

    always_comb begin
        l_rdata = rdata_v[PORT_L];
        r_rdata = rdata_v[PORT_R];
        l_irq_n = irq_v[PORT_L];
        r_irq_n = irq_v[PORT_R];
    end

    // R6: a sender reading its own outgoing mailbox leaves the receiver's line alone
    assert_sender_read_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (l_en && !l_we && l_addr == BOX_TO_R && !(r_en && !r_we && r_addr == BOX_TO_R))
        |=> $stable(r_irq_n)
    );

endmodule

// File: tb/sim_mbx_dualport.sv
`timescale 1ns/1ps
module sim_mbx_dualport;

    localparam int DEPTH = 256;
    localparam int DW    = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam logic [AW-1:0] TOPA = AW'(DEPTH - 1);
    localparam logic [AW-1:0] NXTA = AW'(DEPTH - 2);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en = 0, l_we = 0, r_en = 0, r_we = 0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_irq_n, r_irq_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mbx_dualport #(.DEPTH(DEPTH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_irq_n(l_irq_n),
        .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_irq_n(r_irq_n)
    );

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'(a * 149 + k * 977 + 16'h03C1);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Drives one cycle of both ports starting at a falling edge; returns at the next falling edge
    task automatic cyc(input logic le, input logic lw, input logic [AW-1:0] la, input logic [DW-1:0] ld,
                       input logic re, input logic rw, input logic [AW-1:0] ra, input logic [DW-1:0] rd);
        l_en = le; l_we = lw; l_addr = la; l_wdata = ld;
        r_en = re; r_we = rw; r_addr = ra; r_wdata = rd;
        @(negedge clk);
        l_en = 0; l_we = 0; r_en = 0; r_we = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 l_irq_n after reset", DW'(l_irq_n), 1);
        chk("R1 r_irq_n after reset", DW'(r_irq_n), 1);

        // R2 / R11: left writes, right reads, every non-mailbox address
        for (int a = 0; a < DEPTH - 2; a++) cyc(1, 1, AW'(a), pat(a, 0), 0, 0, '0, '0);
        for (int a = 0; a < DEPTH - 2; a++) begin
            cyc(0, 0, '0, '0, 1, 0, AW'(a), '0);
            chk($sformatf("R2 right reads %0d", a), r_rdata, pat(a, 0));
            held = r_rdata;
            cyc(1, 1, AW'((a + 1) % (DEPTH - 2)), pat((a + 1) % (DEPTH - 2), 0), 0, 0, '0, '0);
            chk($sformatf("R11 right holds %0d", a), r_rdata, held);
        end
        // R2: right writes, left reads
        for (int a = 0; a < DEPTH - 2; a++) cyc(0, 0, '0, '0, 1, 1, AW'(a), pat(a, 1));
        for (int a = 0; a < DEPTH - 2; a++) begin
            cyc(1, 0, AW'(a), '0, 0, 0, '0, '0);
            chk($sformatf("R2 left reads %0d", a), l_rdata, pat(a, 1));
        end
        chk("R6 sweep leaves l_irq_n", DW'(l_irq_n), 1);
        chk("R6 sweep leaves r_irq_n", DW'(r_irq_n), 1);

        // R3: left posts to the right
        cyc(1, 1, TOPA, 16'hA5C3, 0, 0, '0, '0);
        chk("R3 r_irq_n low", DW'(r_irq_n), 0);
        chk("R3 l_irq_n untouched", DW'(l_irq_n), 1);
        // R6: sender read, receiver write to own inbox, unrelated write
        cyc(1, 0, TOPA, '0, 0, 0, '0, '0);
        chk("R8 left reads own outbox", l_rdata, 16'hA5C3);
        chk("R6 sender read keeps r_irq_n", DW'(r_irq_n), 0);
        cyc(1, 1, AW'(5), 16'h1111, 0, 0, '0, '0);
        chk("R6 other write keeps r_irq_n", DW'(r_irq_n), 0);
        cyc(0, 0, '0, '0, 1, 0, NXTA, '0);
        chk("R6 right reads left inbox keeps l_irq_n", DW'(l_irq_n), 1);
        // R5 / R8: right takes the message
        cyc(0, 0, '0, '0, 1, 0, TOPA, '0);
        chk("R8 right reads message", r_rdata, 16'hA5C3);
        chk("R5 r_irq_n released", DW'(r_irq_n), 1);
        cyc(0, 0, '0, '0, 1, 1, TOPA, 16'h7777);
        chk("R6 receiver write to inbox keeps r_irq_n", DW'(r_irq_n), 1);

        // R4: right posts to the left
        cyc(0, 0, '0, '0, 1, 1, NXTA, 16'h3C5A);
        chk("R4 l_irq_n low", DW'(l_irq_n), 0);
        chk("R4 r_irq_n untouched", DW'(r_irq_n), 1);
        cyc(0, 0, '0, '0, 1, 0, NXTA, '0);
        chk("R6 sender read keeps l_irq_n", DW'(l_irq_n), 0);
        cyc(1, 0, NXTA, '0, 0, 0, '0, '0);
        chk("R8 left reads message", l_rdata, 16'h3C5A);
        chk("R5 l_irq_n released", DW'(l_irq_n), 1);

        // R7: post and take together
        cyc(1, 1, TOPA, 16'h0101, 0, 0, '0, '0);
        cyc(1, 1, TOPA, 16'h0202, 1, 0, TOPA, '0);
        chk("R7 r_irq_n stays low", DW'(r_irq_n), 0);
        chk("R10 take sees pre-write word", r_rdata, 16'h0101);
        cyc(0, 0, '0, '0, 1, 0, TOPA, '0);
        chk("R5 r_irq_n released after collision", DW'(r_irq_n), 1);
        chk("R8 second message", r_rdata, 16'h0202);
        cyc(0, 0, '0, '0, 1, 1, NXTA, 16'h0303);
        cyc(1, 0, NXTA, '0, 1, 1, NXTA, 16'h0404);
        chk("R7 l_irq_n stays low", DW'(l_irq_n), 0);
        cyc(1, 0, NXTA, '0, 0, 0, '0, '0);
        chk("R5 l_irq_n released after collision", DW'(l_irq_n), 1);

        // R9: write collision, left wins
        cyc(1, 1, AW'(10), 16'hBEEF, 1, 1, AW'(10), 16'hDEAD);
        cyc(0, 0, '0, '0, 1, 0, AW'(10), '0);
        chk("R9 left data stored", r_rdata, 16'hBEEF);
        // R10: read-before-write across ports
        cyc(1, 1, AW'(11), 16'h4242, 1, 0, AW'(11), '0);
        chk("R10 right sees old word", r_rdata, pat(11, 1));
        cyc(1, 0, AW'(12), '0, 1, 1, AW'(12), 16'h9999);
        chk("R10 left sees old word", l_rdata, pat(12, 1));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule